// File: doc/BRIEF.md
# Execute Unit with Condition-Code Register

This block is the 16-bit execute stage of a small load/store processor. In one combinational pass it produces a result from a first register operand and a second operand. The second operand is either a second register or a 5-bit immediate field that is sign-extended to the data width. The operations are addition, bitwise AND, bitwise XOR and a barrel shift. The shift amount and the shift kind come from the low instruction bits. Memory data returned by a load passes through the same result path: a whole word unchanged, or one byte sign-extended to 16 bits.

A three-flag condition-code register (negative, zero, positive) captures the sign class of the result on the clock edge where the set strobe is high. The sequencer raises that strobe for arithmetic, logic, shift and load operations that must update the codes. The register comes out of reset with only the zero flag set. The asynchronous reset input is released through a two-stage synchronizer.

Top module: `exu_top`

## Requirements
- R1: With op_sel = 000 (add), result equals src_a plus the second operand, modulo 2^16.
- R2: With op_sel = 001 (and), result equals the bitwise AND of src_a and the second operand.
- R3: With op_sel = 010 (xor), result equals the bitwise XOR of src_a and the second operand.
- R4: The second operand is ir_low[4:0] sign-extended to 16 bits when ir_low[5] is 1. It is src_b when ir_low[5] is 0, and ir_low[4:0] then has no effect on the result.
- R5: With op_sel = 011 (shift), result is src_a shifted by ir_low[3:0] places. ir_low[5:4] selects the kind: 00 shifts left with zero fill, 01 shifts right with zero fill, 11 shifts right filling with src_a[15]. A zero amount returns src_a.
- R6: With op_sel = 100 (word load), result equals mem_data.
- R7: With op_sel = 101 (byte load), result is mem_data[15:8] sign-extended when byte_hi is 1, and mem_data[7:0] sign-extended when byte_hi is 0.
- R8: After reset the flags read flag_n = 0, flag_z = 1, flag_p = 0.
- R9: On a rising clock edge with set_cc high, the flags take the class of result: flag_n alone if result[15] is 1, flag_z alone if result is zero, flag_p alone otherwise. Exactly one flag is high at all times.
- R10: On a rising clock edge with set_cc low, the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code (add, and, xor, shift, word load, byte load) |
| ir_low | input | 6 | Low instruction bits: operand select, immediate, shift kind and amount |
| src_a | input | 16 | First register operand |
| src_b | input | 16 | Second register operand |
| mem_data | input | 16 | Word returned by memory for loads |
| byte_hi | input | 1 | Selects the upper byte for byte loads |
| set_cc | input | 1 | Update strobe for the condition codes |
| result | output | 16 | Combinational result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
The bench drives the most negative immediate and an immediate that cancels the register to zero. A design that zero-extended the immediate, or that let the immediate bits leak into the register form, would return a wrong sum there. Shifts of 0x8000 by fifteen places in both right-shift kinds expose a fill bit taken from the wrong source. A zero shift amount catches a barrel stage that always shifts. Byte loads with bit 7 set in each half, and a strobe-low operation followed by a read of the flags, reveal a swapped byte select, a missing sign extension, or codes that update without the strobe.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_AND = 3'b001,
    OP_XOR = 3'b010,
    OP_SHF = 3'b011,
    OP_LDW = 3'b100,
    OP_LDB = 3'b101
  } exu_op_e;

  localparam logic [2:0] CC_NEG = 3'b100;
  localparam logic [2:0] CC_ZRO = 3'b010;
  localparam logic [2:0] CC_POS = 3'b001;
endpackage

// File: rtl/exu_rst_sync.sv
module exu_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;
endmodule

// File: rtl/exu_operand_sel.sv
module exu_operand_sel #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0] operand
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm_field[IMM_W-1]}}, imm_field};

  always_comb begin
    if (use_imm) operand = imm_ext;
    else         operand = reg_val;
  end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]         din,
  input  logic [$clog2(DATA_W)-1:0] amount,
  input  logic                      go_right,
  input  logic                      arith,
  output logic [DATA_W-1:0]         dout
);
  localparam int STAGES = $clog2(DATA_W);

  logic              fill;
  logic [DATA_W-1:0] stage [0:STAGES];

  assign fill     = go_right & arith & din[DATA_W-1];
  assign stage[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [DATA_W-1:0] moved;
    always_comb begin
      if (go_right) moved = {{SH{fill}}, stage[s][DATA_W-1:SH]};
      else          moved = {stage[s][DATA_W-SH-1:0], {SH{1'b0}}};
    end
    assign stage[s+1] = amount[s] ? moved : stage[s];
  end

  assign dout = stage[STAGES];
endmodule

// File: rtl/exu_cc_reg.sv
module exu_cc_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_cc,
  input  logic [DATA_W-1:0] value,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p
);
  import exu_pkg::*;

  logic [2:0] cc_q;
  logic [2:0] cc_d;

  always_comb begin
    if (value[DATA_W-1])   cc_d = CC_NEG;
    else if (value == '0)  cc_d = CC_ZRO;
    else                   cc_d = CC_POS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cc_q <= CC_ZRO;
    else if (set_cc) cc_q <= cc_d;
  end

  assign flag_n = cc_q[2];
  assign flag_z = cc_q[1];
  assign flag_p = cc_q[0];

  // R8
  cc_reset_val_chk: assert property (@(posedge clk) $rose(rst_n) |-> (cc_q == CC_ZRO));

  // R9
  cc_single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_n, flag_z, flag_p}) == 1);

  // R9
  cc_zero_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cc && value == '0) |=> flag_z);

  // R9
  cc_neg_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cc && value[DATA_W-1]) |=> flag_n);

  // R10
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_cc |=> $stable({flag_n, flag_z, flag_p}));
endmodule

// File: rtl/exu_top.sv
module exu_top #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  op_sel,
  input  logic [5:0]  ir_low,
  input  logic [15:0] src_a,
  input  logic [15:0] src_b,
  input  logic [15:0] mem_data,
  input  logic        byte_hi,
  input  logic        set_cc,
  output logic [15:0] result,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_p
);
  import exu_pkg::*;

  localparam int AMT_W  = $clog2(DATA_W);
  localparam int BEXT_W = DATA_W - BYTE_W;

  logic              rst_sync_n;
  logic [DATA_W-1:0] op2;
  logic [DATA_W-1:0] shifted;
  logic [BYTE_W-1:0] ld_byte;
  logic [DATA_W-1:0] ld_byte_ext;

  exu_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  exu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand_sel (
    .use_imm   (ir_low[5]),
    .imm_field (ir_low[IMM_W-1:0]),
    .reg_val   (src_b),
    .operand   (op2)
  );

  exu_shifter #(.DATA_W(DATA_W)) u_shifter (
    .din      (src_a),
    .amount   (ir_low[AMT_W-1:0]),
    .go_right (ir_low[4]),
    .arith    (ir_low[5]),
    .dout     (shifted)
  );

  always_comb begin
    if (byte_hi) ld_byte = mem_data[DATA_W-1 -: BYTE_W];
    else         ld_byte = mem_data[BYTE_W-1:0];
    ld_byte_ext = {{BEXT_W{ld_byte[BYTE_W-1]}}, ld_byte};
  end

  always_comb begin
    case (op_sel)
      OP_ADD:  result = src_a + op2;
      OP_AND:  result = src_a & op2;
      OP_XOR:  result = src_a ^ op2;
      OP_SHF:  result = shifted;
      OP_LDW:  result = mem_data;
      OP_LDB:  result = ld_byte_ext;
      default: result = '0;
    endcase
  end

  exu_cc_reg #(.DATA_W(DATA_W)) u_cc_reg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_cc (set_cc),
    .value  (result),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_p (flag_p)
  );

  // R7
  ldb_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == OP_LDB) |-> (result[DATA_W-1:BYTE_W] == {BEXT_W{result[BYTE_W-1]}}));

  // R5
  shf_zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == OP_SHF && ir_low[AMT_W-1:0] == '0) |-> (result == src_a));

  // R4
  add_imm_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == OP_ADD && ir_low[5] && ir_low[IMM_W-1:0] == '0) |-> (result == src_a));

  // R1
  add_reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == OP_ADD && !ir_low[5] && src_b == '0) |-> (result == src_a));
endmodule

// File: tb/exu_top_bench.sv
module exu_top_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic [5:0]  ir_low;
  logic [15:0] src_a;
  logic [15:0] src_b;
  logic [15:0] mem_data;
  logic        byte_hi;
  logic        set_cc;
  logic [15:0] result;
  logic        flag_n;
  logic        flag_z;
  logic        flag_p;

  int   n_checks;
  int   n_fails;
  logic done;
  logic [2:0] model_cc;

  logic [15:0] exp_res_q [$];
  logic [2:0]  exp_cc_q  [$];
  string       tag_q     [$];

  exu_top u_exu_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sel   (op_sel),
    .ir_low   (ir_low),
    .src_a    (src_a),
    .src_b    (src_b),
    .mem_data (mem_data),
    .byte_hi  (byte_hi),
    .set_cc   (set_cc),
    .result   (result),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_p   (flag_p)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [2:0] class_of(input logic [15:0] v);
    if (v[15])           return 3'b100;
    else if (v == 16'h0) return 3'b010;
    else                 return 3'b001;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [5:0] ir,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] mem, input logic bhi,
                       input logic setc, input logic [15:0] exp_res,
                       input string tag);
    @(posedge clk);
    #1;
    op_sel   = op;
    ir_low   = ir;
    src_a    = a;
    src_b    = b;
    mem_data = mem;
    byte_hi  = bhi;
    set_cc   = setc;
    exp_res_q.push_back(exp_res);
    exp_cc_q.push_back(model_cc);
    tag_q.push_back(tag);
    if (setc) model_cc = class_of(exp_res);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (exp_res_q.size() > 0) begin
      logic [15:0] er;
      logic [2:0]  ec;
      string       tg;
      er = exp_res_q.pop_front();
      ec = exp_cc_q.pop_front();
      tg = tag_q.pop_front();
      n_checks++;
      if (result !== er) begin
        n_fails++;
        $display("FAIL %s result: actual %h expected %h", tg, result, er);
      end
      n_checks++;
      if ({flag_n, flag_z, flag_p} !== ec) begin
        n_fails++;
        $display("FAIL %s/R9 flags nzp: actual %b expected %b", tg,
                 {flag_n, flag_z, flag_p}, ec);
      end
    end
  end

  initial begin
    done = 1'b0;
    #(8 * 20000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    model_cc = 3'b010;
    rst_n    = 1'b0;
    op_sel   = 3'b100;
    ir_low   = 6'h0;
    src_a    = 16'h0;
    src_b    = 16'h0;
    mem_data = 16'h0;
    byte_hi  = 1'b0;
    set_cc   = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if ({flag_n, flag_z, flag_p} !== 3'b010) begin
      n_fails++;
      $display("FAIL R8 reset flags: actual %b expected 010", {flag_n, flag_z, flag_p});
    end

    // R1 R4: register form, immediate bits ignored
    drive(3'b000, 6'b010101, 16'h1234, 16'h0FF0, 16'h0, 1'b0, 1'b1, 16'h2224, "R1/R4 add reg");
    // R4: most negative immediate
    drive(3'b000, 6'b110000, 16'h0005, 16'h7777, 16'h0, 1'b0, 1'b1, 16'hFFF5, "R4 add imm -16");
    // R1: immediate cancels to zero
    drive(3'b000, 6'b111011, 16'h0005, 16'h7777, 16'h0, 1'b0, 1'b1, 16'h0000, "R1 add to zero");
    // R2
    drive(3'b001, 6'b011111, 16'hF0F0, 16'h3C3C, 16'h0, 1'b0, 1'b1, 16'h3030, "R2 and reg");
    drive(3'b001, 6'b101111, 16'hABCD, 16'hFFFF, 16'h0, 1'b0, 1'b1, 16'h000D, "R2 and imm 15");
    // R3
    drive(3'b010, 6'b111111, 16'h00FF, 16'h0000, 16'h0, 1'b0, 1'b1, 16'hFF00, "R3 xor imm -1");
    // R10: strobe low, flags must stay negative
    drive(3'b010, 6'b000000, 16'h5A5A, 16'h5A5A, 16'h0, 1'b0, 1'b0, 16'h0000, "R3/R10 xor no set");
    // R5 shifts
    drive(3'b011, 6'b000011, 16'h1001, 16'h0, 16'h0, 1'b0, 1'b1, 16'h8008, "R5/R10 shl 3");
    drive(3'b011, 6'b011111, 16'h8000, 16'h0, 16'h0, 1'b0, 1'b1, 16'h0001, "R5 lsr 15");
    drive(3'b011, 6'b111111, 16'h8000, 16'h0, 16'h0, 1'b0, 1'b1, 16'hFFFF, "R5 asr 15");
    drive(3'b011, 6'b110100, 16'h7F00, 16'h0, 16'h0, 1'b0, 1'b1, 16'h07F0, "R5 asr positive");
    drive(3'b011, 6'b000000, 16'hBEEF, 16'h0, 16'h0, 1'b0, 1'b1, 16'hBEEF, "R5 amount 0");
    // R6
    drive(3'b100, 6'b000000, 16'h1111, 16'h2222, 16'h0000, 1'b0, 1'b1, 16'h0000, "R6 ldw zero");
    // R7
    drive(3'b101, 6'b000000, 16'h0, 16'h0, 16'h80FF, 1'b1, 1'b1, 16'hFF80, "R7 ldb hi neg");
    drive(3'b101, 6'b000000, 16'h0, 16'h0, 16'h807F, 1'b0, 1'b1, 16'h007F, "R7 ldb lo pos");
    drive(3'b101, 6'b000000, 16'h0, 16'h0, 16'h1200, 1'b0, 1'b1, 16'h0000, "R7 ldb lo zero");
    // R10: final read of flags after last update, strobe low
    drive(3'b100, 6'b000000, 16'h0, 16'h0, 16'h1111, 1'b0, 1'b0, 16'h1111, "R6/R10 ldw hold");
    drive(3'b100, 6'b000000, 16'h0, 16'h0, 16'h8000, 1'b0, 1'b0, 16'h8000, "R10 hold again");

    @(posedge clk);
    #1 set_cc = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule